// File: doc/BRIEF.md
# Platform Power Rail Sequencer

This block runs the timed bring-up and tear-down of a laptop chipset's supply rails and handshake lines. A power-on request received while the platform is off starts a fixed march. The primary rails come up first, then the 5 V rail together with the suspend acknowledge, then the deep-sleep power-good. The resume-well reset is released next, the embedded-controller enable follows, and finally a generated power-button pulse is sent. After the pulse the sequencer polls once per millisecond for the fully-on sleep state. If that state does not appear within a bounded number of polls, it tears everything down again.

Once the platform is running, the block tracks the system power-good input. It raises the hub power-good at once and the platform power-good a fixed time later. When power-good drops, it removes them in the reverse order. A power-off request, or the chipset reaching S5 with its suspend power-down acknowledge raised, triggers the tear-down. The tear-down removes the outputs one per clock in a fixed order, with a minimum gap before the primary rails go.

Every millisecond delay counts pulses of a shared 1 ms tick. The two sub-microsecond and sub-millisecond gaps are counted in clock cycles, and their cycle counts are derived from a clock-frequency parameter. The block also reports the decoded platform power state, and a busy flag that is high while any sequence is in flight.

Top module: `pwr_seq_top`

## Requirements
- R1: `pwr_state` encodes OFF=0, S5=1, S3=2, S0=3. It decodes combinationally from the present inputs by priority: `resume_rst_n` low gives OFF, otherwise `sleep4_n` low gives S5, otherwise `sleep3_n` low gives S3, otherwise S0.
- R2: During and right after reset, every enable and power-good output is low. `resume_rst_n` is low, `btn_n` is high, `busy` is low and `pwr_state` is OFF.
- R3: A power-on request seen while off raises `prim_en` and `busy` at the next edge. `aux5_en` and `susp_ack` rise together exactly PRIM cycles later, where PRIM is 200 us of `CLK_HZ` rounded up with a minimum of 1. `deep_pwr_ok` rises RAIL_MS ticks after that, and `resume_rst_n` rises one cycle after `deep_pwr_ok`.
- R4: `ec_ctl_en` rises PCH_MS ticks after `resume_rst_n` rises. `btn_n` falls ACK_MS ticks after `ec_ctl_en` rises.
- R5: `btn_n` stays low for exactly BTN_MS ticks and then returns high.
- R6: After the button pulse, each tick checks for decoded state S0. If S0 is seen on a tick, the block rests with `busy` low at that tick's edge. If the S0_TRIES-th tick after the pulse passes without S0, the tear-down of R7 starts at that edge.
- R7: The tear-down drops one output per clock in this order: `plat_pwr_ok`, `hub_pwr_ok`, `ec_ctl_en`, `resume_rst_n`, then `aux5_en` with `susp_ack`. `prim_en` falls exactly GAP cycles after that, where GAP is 400 ns of `CLK_HZ` rounded up with a minimum of 1. `deep_pwr_ok` and `busy` fall one cycle after `prim_en`.
- R8: While running, a high `sys_pgood` raises `hub_pwr_ok` at the next edge and raises `plat_pwr_ok` PG_MS ticks later. When `sys_pgood` falls, `plat_pwr_ok` drops at the next edge and `hub_pwr_ok` drops one cycle after it.
- R9: While resting in the running state with decoded state S5 and `susp_dn_ack` high, the tear-down starts at the next edge. S5 with `susp_dn_ack` low changes nothing.
- R10: A power-on request is ignored unless the block rests in the off state. A power-off request is ignored while off. Both are ignored while `busy` is high.
- R11: `busy` is high from the first step of any sequence (power-on, tear-down, power-good ramp or power-good drop) until it completes. A delay of N ms ends on the N-th tick strictly after its step began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| on_req | input | 1 | Power-on request |
| off_req | input | 1 | Power-off request |
| sleep4_n | input | 1 | Chipset deep sleep line, low when the S4 plane is unpowered |
| sleep3_n | input | 1 | Chipset sleep line, low when the S3 plane is unpowered |
| sys_pgood | input | 1 | System power-good |
| susp_dn_ack | input | 1 | Chipset suspend power-down acknowledge |
| prim_en | output | 1 | Primary rail enable |
| aux5_en | output | 1 | 5 V rail enable |
| susp_ack | output | 1 | Suspend acknowledge to the chipset |
| deep_pwr_ok | output | 1 | Deep-sleep well power-good |
| resume_rst_n | output | 1 | Resume-well reset, active low |
| ec_ctl_en | output | 1 | Lets the processor drive the sleep lines |
| btn_n | output | 1 | Power button line, active low |
| hub_pwr_ok | output | 1 | Chipset hub power-good |
| plat_pwr_ok | output | 1 | Platform power-good |
| pwr_state | output | 2 | Decoded power state (OFF=0, S5=1, S3=2, S0=3) |
| busy | output | 1 | A sequence is in flight |

## Verification
The assertions hold the rail dependencies on every cycle. The 5 V rail never runs without the primary rail, the resume reset never releases without deep power-good, and the controller enable never runs with the resume reset held. Platform power-good never runs without hub power-good, and it only rises while system power-good is high. They also check the edge orderings: hub power-good falls after platform power-good, deep power-good falls after the primary rail, and the primary rail only rises from the OFF state. The exact step lengths in ticks and cycles, the S0 poll limit, the auto-off condition and the ignoring of requests can only be shown by the bench's timed scenarios.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    PS_OFF = 2'd0,
    PS_S5  = 2'd1,
    PS_S3  = 2'd2,
    PS_S0  = 2'd3
  } pstate_t;

  typedef enum logic [4:0] {
    SQ_OFF, SQ_PRIM, SQ_AUX, SQ_DEEP, SQ_RESUME, SQ_ECEN, SQ_BTN, SQ_WAIT,
    SQ_RUN, SQ_PGW, SQ_PGON, SQ_PGDROP,
    SQ_OFF_PLAT, SQ_OFF_HUB, SQ_OFF_EC, SQ_OFF_RES, SQ_OFF_AUX, SQ_OFF_PRIM
  } seq_t;

  typedef struct packed {
    logic prim;
    logic aux5;
    logic susack;
    logic deep;
    logic resume_n;
    logic ec;
    logic btn_n;
    logic hub;
    logic plat;
    logic busy;
  } pins_t;

  // cycles covering a span in ns, rounded up, never below one
  function automatic int unsigned ns_to_cycles(input longint unsigned hz,
                                               input longint unsigned ns);
    longint unsigned c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic pstate_t decode_state(input logic resume_n,
                                           input logic s4_n,
                                           input logic s3_n);
    if (!resume_n)  return PS_OFF;
    else if (!s4_n) return PS_S5;
    else if (!s3_n) return PS_S3;
    else            return PS_S0;
  endfunction

  function automatic logic is_teardown(input seq_t s);
    return (s == SQ_OFF_PLAT) || (s == SQ_OFF_HUB) || (s == SQ_OFF_EC) ||
           (s == SQ_OFF_RES) || (s == SQ_OFF_AUX) || (s == SQ_OFF_PRIM);
  endfunction

  // output pattern held in each step
  function automatic pins_t pins_for(input seq_t s);
    pins_t p;
    p = '0;
    p.btn_n = 1'b1;
    case (s)
      SQ_PRIM:     begin p.prim = 1; p.busy = 1; end
      SQ_AUX:      begin p.prim = 1; p.aux5 = 1; p.susack = 1; p.busy = 1; end
      SQ_DEEP:     begin p.prim = 1; p.aux5 = 1; p.susack = 1; p.deep = 1; p.busy = 1; end
      SQ_RESUME:   begin p.prim = 1; p.aux5 = 1; p.susack = 1; p.deep = 1; p.resume_n = 1;
                         p.busy = 1; end
      SQ_ECEN, SQ_WAIT, SQ_OFF_HUB:
                   begin p.prim = 1; p.aux5 = 1; p.susack = 1; p.deep = 1; p.resume_n = 1;
                         p.ec = 1; p.busy = 1; end
      SQ_BTN:      begin p.prim = 1; p.aux5 = 1; p.susack = 1; p.deep = 1; p.resume_n = 1;
                         p.ec = 1; p.btn_n = 0; p.busy = 1; end
      SQ_RUN:      begin p.prim = 1; p.aux5 = 1; p.susack = 1; p.deep = 1; p.resume_n = 1;
                         p.ec = 1; end
      SQ_PGW, SQ_PGDROP, SQ_OFF_PLAT:
                   begin p.prim = 1; p.aux5 = 1; p.susack = 1; p.deep = 1; p.resume_n = 1;
                         p.ec = 1; p.hub = 1; p.busy = 1; end
      SQ_PGON:     begin p.prim = 1; p.aux5 = 1; p.susack = 1; p.deep = 1; p.resume_n = 1;
                         p.ec = 1; p.hub = 1; p.plat = 1; end
      SQ_OFF_EC:   begin p.prim = 1; p.aux5 = 1; p.susack = 1; p.deep = 1; p.resume_n = 1;
                         p.busy = 1; end
      SQ_OFF_RES:  begin p.prim = 1; p.aux5 = 1; p.susack = 1; p.deep = 1; p.busy = 1; end
      SQ_OFF_AUX:  begin p.prim = 1; p.deep = 1; p.busy = 1; end
      SQ_OFF_PRIM: begin p.deep = 1; p.busy = 1; end
      default:     ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/pwr_state_dec.sv
`timescale 1ns/1ps
module pwr_state_dec
  import pwr_seq_pkg::*;
(
  input  logic    resume_n,
  input  logic    s4_n,
  input  logic    s3_n,
  output pstate_t state
);
  assign state = decode_state(resume_n, s4_n, s3_n);
endmodule

// File: rtl/pwr_step_timer.sv
`timescale 1ns/1ps
module pwr_step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             use_tick,
  input  logic [CNT_W-1:0] lim,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             step_en;

  assign step_en = use_tick ? tick : 1'b1;
  assign done    = step_en && (cnt_q == lim - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (step_en) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/pwr_seq_top.sv
`timescale 1ns/1ps
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned     PRIM_NS  = 200_000,
  parameter int unsigned     GAP_NS   = 400,
  parameter int unsigned     RAIL_MS  = 10,
  parameter int unsigned     PCH_MS   = 95,
  parameter int unsigned     ACK_MS   = 200,
  parameter int unsigned     BTN_MS   = 32,
  parameter int unsigned     S0_TRIES = 5000,
  parameter int unsigned     PG_MS    = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       on_req,
  input  logic       off_req,
  input  logic       sleep4_n,
  input  logic       sleep3_n,
  input  logic       sys_pgood,
  input  logic       susp_dn_ack,
  output logic       prim_en,
  output logic       aux5_en,
  output logic       susp_ack,
  output logic       deep_pwr_ok,
  output logic       resume_rst_n,
  output logic       ec_ctl_en,
  output logic       btn_n,
  output logic       hub_pwr_ok,
  output logic       plat_pwr_ok,
  output logic [1:0] pwr_state,
  output logic       busy
);
  localparam int unsigned PRIM_CYC = ns_to_cycles(CLK_HZ, PRIM_NS);
  localparam int unsigned GAP_CYC  = ns_to_cycles(CLK_HZ, GAP_NS);
  localparam int unsigned MAX_LIM  = umax(umax(umax(PRIM_CYC, GAP_CYC), umax(RAIL_MS, PCH_MS)),
                                          umax(umax(ACK_MS, BTN_MS), umax(S0_TRIES, PG_MS)));
  localparam int          CNT_W    = $clog2(MAX_LIM + 1);

  seq_t             state_q, state_d;
  pins_t            pins_q, pins_d;
  pstate_t          pstate;
  logic [CNT_W-1:0] lim;
  logic             use_tick;
  logic             step_done;
  logic             step_clr;
  logic             in_s0;
  logic             want_off;

  pwr_state_dec u_dec (
    .resume_n (pins_q.resume_n),
    .s4_n     (sleep4_n),
    .s3_n     (sleep3_n),
    .state    (pstate)
  );

  pwr_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (step_clr),
    .tick     (tick_ms),
    .use_tick (use_tick),
    .lim      (lim),
    .done     (step_done)
  );

  assign in_s0    = (pstate == PS_S0);
  assign want_off = off_req || ((pstate == PS_S5) && susp_dn_ack);
  assign step_clr = (state_d != state_q);

  // step length, chosen from the current step only
  always_comb begin
    lim      = CNT_W'(1);
    use_tick = 1'b1;
    case (state_q)
      SQ_PRIM:    begin lim = CNT_W'(PRIM_CYC); use_tick = 1'b0; end
      SQ_AUX:     lim = CNT_W'(RAIL_MS);
      SQ_RESUME:  lim = CNT_W'(PCH_MS);
      SQ_ECEN:    lim = CNT_W'(ACK_MS);
      SQ_BTN:     lim = CNT_W'(BTN_MS);
      SQ_WAIT:    lim = CNT_W'(S0_TRIES);
      SQ_PGW:     lim = CNT_W'(PG_MS);
      SQ_OFF_AUX: begin lim = CNT_W'(GAP_CYC); use_tick = 1'b0; end
      default:    ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_OFF:      if (on_req) state_d = SQ_PRIM;
      SQ_PRIM:     if (step_done) state_d = SQ_AUX;
      SQ_AUX:      if (step_done) state_d = SQ_DEEP;
      SQ_DEEP:     state_d = SQ_RESUME;
      SQ_RESUME:   if (step_done) state_d = SQ_ECEN;
      SQ_ECEN:     if (step_done) state_d = SQ_BTN;
      SQ_BTN:      if (step_done) state_d = SQ_WAIT;
      SQ_WAIT: begin
        if (tick_ms && in_s0) state_d = SQ_RUN;
        else if (step_done)   state_d = SQ_OFF_PLAT;
      end
      SQ_RUN: begin
        if (want_off)       state_d = SQ_OFF_PLAT;
        else if (sys_pgood) state_d = SQ_PGW;
      end
      SQ_PGW: begin
        if (!sys_pgood)     state_d = SQ_PGDROP;
        else if (step_done) state_d = SQ_PGON;
      end
      SQ_PGON: begin
        if (want_off)        state_d = SQ_OFF_PLAT;
        else if (!sys_pgood) state_d = SQ_PGDROP;
      end
      SQ_PGDROP:   state_d = SQ_RUN;
      SQ_OFF_PLAT: state_d = SQ_OFF_HUB;
      SQ_OFF_HUB:  state_d = SQ_OFF_EC;
      SQ_OFF_EC:   state_d = SQ_OFF_RES;
      SQ_OFF_RES:  state_d = SQ_OFF_AUX;
      SQ_OFF_AUX:  if (step_done) state_d = SQ_OFF_PRIM;
      SQ_OFF_PRIM: state_d = SQ_OFF;
      default:     state_d = SQ_OFF;
    endcase
  end

  // tear-down steps may only lower the power-good pair
  always_comb begin
    pins_d = pins_for(state_d);
    if (is_teardown(state_d)) begin
      pins_d.hub  = pins_d.hub & pins_q.hub;
      pins_d.plat = pins_d.plat & pins_q.plat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_OFF;
      pins_q  <= pins_for(SQ_OFF);
    end else begin
      state_q <= state_d;
      pins_q  <= pins_d;
    end
  end

  assign prim_en      = pins_q.prim;
  assign aux5_en      = pins_q.aux5;
  assign susp_ack     = pins_q.susack;
  assign deep_pwr_ok  = pins_q.deep;
  assign resume_rst_n = pins_q.resume_n;
  assign ec_ctl_en    = pins_q.ec;
  assign btn_n        = pins_q.btn_n;
  assign hub_pwr_ok   = pins_q.hub;
  assign plat_pwr_ok  = pins_q.plat;
  assign busy         = pins_q.busy;
  assign pwr_state    = pstate;
endmodule

// File: rtl/pwr_seq_chk.sv
`timescale 1ns/1ps
module pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_pgood,
  input logic       prim_en,
  input logic       aux5_en,
  input logic       deep_pwr_ok,
  input logic       resume_rst_n,
  input logic       ec_ctl_en,
  input logic       hub_pwr_ok,
  input logic       plat_pwr_ok,
  input logic [1:0] pwr_state
);
  // R3
  aux_needs_prim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux5_en |-> prim_en);

  // R3
  resume_needs_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_rst_n |-> deep_pwr_ok);

  // R3
  resume_rise_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_rst_n) |-> $past(deep_pwr_ok));

  // R4
  ec_needs_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ec_ctl_en |-> resume_rst_n);

  // R8
  plat_needs_hub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plat_pwr_ok |-> hub_pwr_ok);

  // R8
  plat_rise_pgood_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(plat_pwr_ok) |-> $past(sys_pgood));

  // R8
  hub_fall_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hub_pwr_ok) |-> !$past(plat_pwr_ok));

  // R7
  deep_fall_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(deep_pwr_ok) |-> !$past(prim_en));

  // R10
  prim_rise_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prim_en) |-> ($past(pwr_state) == 2'd0));
endmodule

bind pwr_seq_top pwr_seq_chk i_chk (.*);

// File: tb/test_pwr_seq_top.sv
`timescale 1ns/1ps
module test_pwr_seq_top;
  localparam longint unsigned CLK_HZ = 10_000_000;
  localparam int TICK_DIV = 50;
  localparam int RAIL_MS  = 3;
  localparam int PCH_MS   = 4;
  localparam int ACK_MS   = 5;
  localparam int BTN_MS   = 2;
  localparam int S0_TRIES = 6;
  localparam int PG_MS    = 3;
  localparam int PRIM_EXP = 2000; // 200 us at 10 MHz
  localparam int GAP_EXP  = 4;    // 400 ns at 10 MHz
  localparam int WATCHDOG = 150000;

  // decode vectors: {sleep4_n, sleep3_n, expected state}
  localparam logic [3:0] DEC_VEC [5] = '{
    {1'b1, 1'b1, 2'd3}, {1'b1, 1'b0, 2'd2}, {1'b0, 1'b1, 2'd1},
    {1'b0, 1'b0, 2'd1}, {1'b1, 1'b1, 2'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0;
  logic on_req = 1'b0, off_req = 1'b0, sleep4_n = 1'b0, sleep3_n = 1'b0;
  logic sys_pgood = 1'b0, susp_dn_ack = 1'b0;
  logic prim_en, aux5_en, susp_ack, deep_pwr_ok, resume_rst_n, ec_ctl_en;
  logic btn_n, hub_pwr_ok, plat_pwr_ok, busy;
  logic [1:0] pwr_state;

  always #2 clk = ~clk;

  pwr_seq_top #(
    .CLK_HZ(CLK_HZ), .PRIM_NS(200_000), .GAP_NS(400), .RAIL_MS(RAIL_MS),
    .PCH_MS(PCH_MS), .ACK_MS(ACK_MS), .BTN_MS(BTN_MS), .S0_TRIES(S0_TRIES),
    .PG_MS(PG_MS)
  ) i_pwr_seq_top (.*);

  int checks = 0, errors = 0, div = 0;
  longint cyc = 0, tk = 0;
  logic [9:0] cur, prv = '0;
  longint rise_cyc [10], fall_cyc [10], rise_tk [10], fall_tk [10];
  // 0 prim, 1 aux5, 2 susp_ack, 3 deep, 4 resume, 5 ec, 6 btn, 7 hub, 8 plat, 9 busy
  assign cur = {busy, plat_pwr_ok, hub_pwr_ok, btn_n, ec_ctl_en, resume_rst_n,
                deep_pwr_ok, susp_ack, aux5_en, prim_en};

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor, tick source and watchdog, all away from the rising edge
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < 10; i++) begin
      if (cur[i] !== prv[i]) begin
        if (cur[i] === 1'b1) begin rise_cyc[i] = cyc; rise_tk[i] = tk; end
        else begin fall_cyc[i] = cyc; fall_tk[i] = tk; end
      end
    end
    prv = cur;
    if (div == TICK_DIV - 1) begin
      div = 0;
      tick_ms <= 1'b1;
      tk++;
    end else begin
      div++;
      tick_ms <= 1'b0;
    end
    if (cyc > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_on();
    on_req = 1'b1; step(); on_req = 1'b0;
  endtask

  task automatic pulse_off();
    off_req = 1'b1; step(); off_req = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    longint t0;
    t0 = tk;
    while (tk < t0 + n) step();
  endtask

  // full bring-up with a chipset that enters S0 two ticks after the button pulse
  task automatic power_up();
    longint exp_tk;
    pulse_on();
    while (btn_n) step();
    while (!btn_n) step();
    wait_ticks(2);
    sleep4_n = 1'b1;
    sleep3_n = 1'b1;
    exp_tk = tick_ms ? tk : tk + 1;
    while (busy) step();
    chk("R6 rest reached on the S0 tick", fall_tk[9], exp_tk);
  endtask

  initial begin
    longint snap, prim_seen;
    repeat (4) step();
    // R2 reset values
    chk("R2 prim_en in reset", prim_en, 0);
    chk("R2 resume_rst_n in reset", resume_rst_n, 0);
    chk("R2 btn_n in reset", btn_n, 1);
    rst_n = 1'b1;
    step();
    chk("R2 enables after reset", {aux5_en, susp_ack, deep_pwr_ok, ec_ctl_en,
                                   hub_pwr_ok, plat_pwr_ok, busy}, 0);
    chk("R2 state after reset", pwr_state, 0);

    // bring-up with S0 reached
    power_up();
    chk("R3 busy rises with primary", rise_cyc[9], rise_cyc[0]);
    chk("R3 primary to 5 V in cycles", rise_cyc[1] - rise_cyc[0], PRIM_EXP);
    chk("R3 suspend ack with 5 V", rise_cyc[2], rise_cyc[1]);
    chk("R3 5 V to deep power-good in ticks", rise_tk[3] - rise_tk[1], RAIL_MS);
    chk("R3 deep power-good to resume release", rise_cyc[4] - rise_cyc[3], 1);
    chk("R4 resume release to controller enable", rise_tk[5] - rise_tk[4], PCH_MS);
    chk("R4 controller enable to button press", fall_tk[6] - rise_tk[5], ACK_MS);
    chk("R5 button low length", rise_tk[6] - fall_tk[6], BTN_MS);
    chk("R6 primary still on", prim_en, 1);

    // R1 decode table
    foreach (DEC_VEC[i]) begin
      sleep4_n = DEC_VEC[i][3];
      sleep3_n = DEC_VEC[i][2];
      #1;
      chk("R1 decoded state", pwr_state, DEC_VEC[i][1:0]);
      step();
    end

    // R10 on-request while running is ignored
    prim_seen = rise_cyc[0];
    pulse_on();
    repeat (3) step();
    chk("R10 on request ignored when running", busy, 0);
    chk("R10 primary not restarted", rise_cyc[0], prim_seen);

    // R8 power-good ramp and drop
    snap = cyc;
    sys_pgood = 1'b1;
    while (!plat_pwr_ok) step();
    chk("R8 hub power-good follows pgood", rise_cyc[7] - snap, 1);
    chk("R11 busy during power-good ramp", rise_cyc[9], rise_cyc[7]);
    chk("R8 hub to platform power-good in ticks", rise_tk[8] - rise_tk[7], PG_MS);
    snap = cyc;
    sys_pgood = 1'b0;
    repeat (3) step();
    chk("R8 platform power-good drops first", fall_cyc[8] - snap, 1);
    chk("R8 hub power-good drops next", fall_cyc[7] - fall_cyc[8], 1);
    sys_pgood = 1'b1;
    while (!plat_pwr_ok || busy) step();

    // R7 requested tear-down
    snap = cyc;
    pulse_off();
    while (deep_pwr_ok) step();
    chk("R7 platform power-good off first", fall_cyc[8] - snap, 1);
    chk("R7 hub power-good off", fall_cyc[7] - fall_cyc[8], 1);
    chk("R7 controller enable off", fall_cyc[5] - fall_cyc[7], 1);
    chk("R7 resume reset asserted", fall_cyc[4] - fall_cyc[5], 1);
    chk("R7 5 V off", fall_cyc[1] - fall_cyc[4], 1);
    chk("R7 suspend ack off with 5 V", fall_cyc[2], fall_cyc[1]);
    chk("R7 gap before primary off", fall_cyc[0] - fall_cyc[1], GAP_EXP);
    chk("R7 deep power-good off after primary", fall_cyc[3] - fall_cyc[0], 1);
    chk("R7 busy ends with deep power-good", fall_cyc[9], fall_cyc[3]);
    chk("R1 state off after tear-down", pwr_state, 0);
    sys_pgood = 1'b0;
    sleep4_n = 1'b0;
    sleep3_n = 1'b0;

    // R10 off-request while off is ignored
    pulse_off();
    repeat (3) step();
    chk("R10 off request ignored when off", {busy, prim_en}, 0);

    // R6 abort when S0 never arrives; R10 requests while busy ignored
    pulse_on();
    while (!resume_rst_n) step();
    pulse_off();
    pulse_on();
    while (btn_n) step();
    chk("R10 off request ignored while busy", ec_ctl_en, 1);
    while (!btn_n) step();
    while (busy) step();
    chk("R6 abort after the last poll", fall_tk[5] - rise_tk[6], S0_TRIES);
    chk("R6 primary removed after abort", prim_en, 0);

    // R9 automatic tear-down in S5
    power_up();
    sleep4_n = 1'b0;
    repeat (5) step();
    chk("R9 S5 without acknowledge keeps rails", {prim_en, busy}, 2'b10);
    snap = cyc;
    susp_dn_ack = 1'b1;
    while (deep_pwr_ok) step();
    chk("R9 acknowledge starts tear-down", fall_cyc[5] - snap, 3);
    chk("R9 state off after auto tear-down", pwr_state, 0);
    susp_dn_ack = 1'b0;

    finish_run();
  end
endmodule